// File: doc/BRIEF.md
# Indirect-Access Serial Register Port

This block is the slave side of a four-signal serial port (SCLK, active-low chip select, DIN, DOUT) that gives a host access to a converter core's control and result registers. The host never addresses a data register directly. It first shifts in an 8-bit command word. That word names one register and states whether the next access reads it or writes it. The port then moves exactly that register's width of bits, MSB first, and goes back to waiting for the next command word.

All serial inputs are resampled into the system clock domain, and the falling edge of SCLK is the only active edge. Chip select can frame each access, with the read MSB driven as soon as select falls. It can also be tied low, in which case framing comes from bit counting alone. There are two ways to get a lost host back in step. Raising chip select partway through an access drops it. A run of ones on DIN, counted on active edges, returns both the port and the register bank to their power-on state. A small register bank with fixed widths stands in for the converter core.

Top module: `serport_regif`

## Requirements
- R1: After reset, dout_oe is 0. The mode, control, filter and gpio outputs hold their power-on values (0x00, 0x07, 0x0045, 0x0000), and the first 8 bits clocked in are treated as a command word.
- R2: A command word is sent MSB first. Bit 7 must be 0, or the whole word is discarded and the next 8 bits are again a command word. Bit 6 set selects a read and clear selects a write. Bits 3..0 give the register address. Bits 5..4 are ignored.
- R3: A write command is followed by the addressed register's width of DIN bits, MSB first. When the last bit arrives, those bits replace the register. Addresses 1 (mode, 8 bits), 2 (control, 8), 4 (filter, 16) and 5 (gpio, 16) can be written.
- R4: A read command is followed by the addressed register's width of bits on DOUT, MSB first. Address 0 returns the 8-bit status input, address 3 returns the 24-bit sample input, and the writable registers return their current contents.
- R5: Once the data bits of an access are complete, the next 8 bits are taken as a new command word.
- R6: A write to address 0, to address 3 (24 bits consumed) or to an unmapped address 6..15 (8 bits consumed) changes no register. A read from an unmapped address returns 8 zero bits.
- R7: When DIN is 1 on 32 consecutive active edges, the port returns to waiting for a command word and all registers return to their power-on values. A run of 31 ones has neither effect.
- R8: DIN is sampled at the falling edge of SCLK, and DOUT moves to the next bit at that edge.
- R9: While chip select is high, dout_oe is 0. Raising chip select after some but not all bits of an access have been shifted abandons that access: no register changes, and the next bits form a command word.
- R10: If chip select rises between a read command and its data, and falls again later, the MSB of the read data is on DOUT with dout_oe at 1 before the first SCLK falling edge.
- R11: With chip select held low for the whole session, back-to-back accesses frame correctly by bit count alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host; falling edge is active |
| cs_n | input | 1 | Active-low chip select |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | High while the port drives dout; low means high impedance |
| status_in | input | 8 | Status byte returned at address 0 |
| sample_in | input | 24 | Conversion result returned at address 3 |
| mode_o | output | 8 | Mode register contents |
| ctrl_o | output | 8 | Control register contents |
| filt_o | output | 16 | Filter register contents |
| gpio_o | output | 16 | Port register contents |

## Verification
The bench covers these corner cases:
- A 31-one run against a 32-one run. An off-by-one ones counter would either reset the bank too early or never reset it.
- A 32-one run that starts inside a 16-bit write. The write must commit before the reset hits.
- A command word with bit 7 set. A port that accepted it would lose byte alignment, and the following read would come back wrong.
- Chip select raised mid-write and raised between a read command and its data. In the first case a wrong design keeps or commits the partial word. In the second it either forgets the pending read or fails to present the MSB when select falls.
- DIN changed while SCLK is low. A port that sampled on the rising edge would capture the inverted value.

// File: rtl/sp_regif_pkg.sv
package sp_regif_pkg;
  localparam int MAX_W  = 24;
  localparam int CNT_W  = $clog2(MAX_W + 1);
  localparam int CMD_W  = 8;
  localparam int ADDR_W = 4;
  localparam int CMD_WE_BIT = CMD_W - 1;
  localparam int CMD_RD_BIT = CMD_W - 2;

  localparam int W_BYTE = 8;
  localparam int W_HALF = 16;
  localparam int W_WORD = 24;

  localparam logic [ADDR_W-1:0] A_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd2;
  localparam logic [ADDR_W-1:0] A_SAMP = 4'd3;
  localparam logic [ADDR_W-1:0] A_FILT = 4'd4;
  localparam logic [ADDR_W-1:0] A_GPIO = 4'd5;

  typedef enum logic [1:0] {
    PH_CMD = 2'd0,
    PH_WR  = 2'd1,
    PH_RD  = 2'd2
  } phase_e;

  function automatic logic [CNT_W-1:0] acc_width(input logic [ADDR_W-1:0] a);
    case (a)
      A_SAMP:         return CNT_W'(W_WORD);
      A_FILT, A_GPIO: return CNT_W'(W_HALF);
      default:        return CNT_W'(W_BYTE);
    endcase
  endfunction
endpackage

// File: rtl/sp_in_sync.sv
module sp_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic fall,
  output logic cs_s,
  output logic din_s
);
  logic [STAGES-1:0] sclk_p, cs_p, din_p;
  logic              sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '1;
      cs_p   <= '1;
      din_p  <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk};
      cs_p   <= {cs_p[STAGES-2:0], cs_n};
      din_p  <= {din_p[STAGES-2:0], din};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign fall  = sclk_d & ~sclk_p[STAGES-1];
  assign cs_s  = cs_p[STAGES-1];
  assign din_s = din_p[STAGES-1];
endmodule

// File: rtl/sp_ones_det.sv
module sp_ones_det #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic cs_s,
  input  logic din_s,
  output logic resync
);
  localparam int RW = $clog2(LIMIT + 1);

  logic [RW-1:0] run_q, run_d;
  logic          hit_q, hit_d;

  always_comb begin
    run_d = run_q;
    hit_d = 1'b0;
    if (cs_s) begin
      run_d = '0;
    end else if (fall) begin
      if (!din_s) begin
        run_d = '0;
      end else if (run_q == RW'(LIMIT - 1)) begin
        run_d = '0;
        hit_d = 1'b1;
      end else begin
        run_d = run_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      hit_q <= 1'b0;
    end else begin
      run_q <= run_d;
      hit_q <= hit_d;
    end
  end

  assign resync = hit_q;
endmodule

// File: rtl/sp_frame.sv
module sp_frame
  import sp_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              cs_s,
  input  logic              din_s,
  input  logic              resync,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [MAX_W-1:0]  rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [MAX_W-1:0]  wr_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              idle,
  output logic [CNT_W-1:0]  bit_cnt
);
  phase_e             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, wid_q, wid_d, nw;
  logic [MAX_W-1:0]   sh_q, sh_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               oe_q, oe_d;
  logic [CMD_W-1:0]   cmd_byte;
  logic               last_bit, partial;

  assign cmd_byte = {sh_q[CMD_W-2:0], din_s};
  assign rd_addr  = cmd_byte[ADDR_W-1:0];
  assign nw       = acc_width(rd_addr);
  assign last_bit = (cnt_q == CNT_W'(1));
  assign partial  = (cnt_q != wid_q);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    wid_d  = wid_q;
    sh_d   = sh_q;
    addr_d = addr_q;
    wr_en  = 1'b0;
    oe_d   = ~cs_s;
    if (resync || (cs_s && partial)) begin
      ph_d  = PH_CMD;
      cnt_d = CNT_W'(CMD_W);
      wid_d = CNT_W'(CMD_W);
      sh_d  = '0;
    end else if (fall && !cs_s) begin
      case (ph_q)
        PH_CMD: begin
          if (last_bit) begin
            if (!cmd_byte[CMD_WE_BIT]) begin
              addr_d = rd_addr;
              cnt_d  = nw;
              wid_d  = nw;
              if (cmd_byte[CMD_RD_BIT]) begin
                ph_d = PH_RD;
                sh_d = rd_data << (CNT_W'(MAX_W) - nw);
              end else begin
                ph_d = PH_WR;
                sh_d = '0;
              end
            end else begin
              cnt_d = CNT_W'(CMD_W);
              wid_d = CNT_W'(CMD_W);
              sh_d  = '0;
            end
          end else begin
            sh_d  = {sh_q[MAX_W-2:0], din_s};
            cnt_d = cnt_q - 1'b1;
          end
        end
        PH_WR: begin
          sh_d  = {sh_q[MAX_W-2:0], din_s};
          cnt_d = cnt_q - 1'b1;
          if (last_bit) begin
            wr_en = 1'b1;
            ph_d  = PH_CMD;
            cnt_d = CNT_W'(CMD_W);
            wid_d = CNT_W'(CMD_W);
            sh_d  = '0;
          end
        end
        PH_RD: begin
          sh_d  = sh_q << 1;
          cnt_d = cnt_q - 1'b1;
          if (last_bit) begin
            ph_d  = PH_CMD;
            cnt_d = CNT_W'(CMD_W);
            wid_d = CNT_W'(CMD_W);
            sh_d  = '0;
          end
        end
        default: begin
          ph_d  = PH_CMD;
          cnt_d = CNT_W'(CMD_W);
          wid_d = CNT_W'(CMD_W);
          sh_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cnt_q  <= CNT_W'(CMD_W);
      wid_q  <= CNT_W'(CMD_W);
      sh_q   <= '0;
      addr_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      wid_q  <= wid_d;
      sh_q   <= sh_d;
      addr_q <= addr_d;
      oe_q   <= oe_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = {sh_q[MAX_W-2:0], din_s};
  assign dout    = (ph_q == PH_RD) ? sh_q[MAX_W-1] : 1'b0;
  assign dout_oe = oe_q;
  assign idle    = (ph_q == PH_CMD);
  assign bit_cnt = cnt_q;
endmodule

// File: rtl/sp_reg_bank.sv
module sp_reg_bank
  import sp_regif_pkg::*;
#(
  parameter logic [W_BYTE-1:0] MODE_RST = 8'h00,
  parameter logic [W_BYTE-1:0] CTRL_RST = 8'h07,
  parameter logic [W_HALF-1:0] FILT_RST = 16'h0045,
  parameter logic [W_HALF-1:0] GPIO_RST = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              resync,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MAX_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [MAX_W-1:0]  rd_data,
  input  logic [W_BYTE-1:0] status_in,
  input  logic [W_WORD-1:0] sample_in,
  output logic [W_BYTE-1:0] mode_q,
  output logic [W_BYTE-1:0] ctrl_q,
  output logic [W_HALF-1:0] filt_q,
  output logic [W_HALF-1:0] gpio_q
);
  logic [W_BYTE-1:0] mode_d, ctrl_d;
  logic [W_HALF-1:0] filt_d, gpio_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[MAX_W-1:W_HALF];

  always_comb begin
    mode_d = mode_q;
    ctrl_d = ctrl_q;
    filt_d = filt_q;
    gpio_d = gpio_q;
    if (resync) begin
      mode_d = MODE_RST;
      ctrl_d = CTRL_RST;
      filt_d = FILT_RST;
      gpio_d = GPIO_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_MODE:  mode_d = wr_data[W_BYTE-1:0];
        A_CTRL:  ctrl_d = wr_data[W_BYTE-1:0];
        A_FILT:  filt_d = wr_data[W_HALF-1:0];
        A_GPIO:  gpio_d = wr_data[W_HALF-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ctrl_q <= CTRL_RST;
      filt_q <= FILT_RST;
      gpio_q <= GPIO_RST;
    end else begin
      mode_q <= mode_d;
      ctrl_q <= ctrl_d;
      filt_q <= filt_d;
      gpio_q <= gpio_d;
    end
  end

  always_comb begin
    case (rd_addr)
      A_STAT:  rd_data = MAX_W'(status_in);
      A_MODE:  rd_data = MAX_W'(mode_q);
      A_CTRL:  rd_data = MAX_W'(ctrl_q);
      A_SAMP:  rd_data = MAX_W'(sample_in);
      A_FILT:  rd_data = MAX_W'(filt_q);
      A_GPIO:  rd_data = MAX_W'(gpio_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/serport_regif.sv
module serport_regif
  import sp_regif_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                RESYNC_ONES = 32,
  parameter logic [W_BYTE-1:0] MODE_RST    = 8'h00,
  parameter logic [W_BYTE-1:0] CTRL_RST    = 8'h07,
  parameter logic [W_HALF-1:0] FILT_RST    = 16'h0045,
  parameter logic [W_HALF-1:0] GPIO_RST    = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [W_BYTE-1:0] status_in,
  input  logic [W_WORD-1:0] sample_in,
  output logic [W_BYTE-1:0] mode_o,
  output logic [W_BYTE-1:0] ctrl_o,
  output logic [W_HALF-1:0] filt_o,
  output logic [W_HALF-1:0] gpio_o
);
  logic              fall, cs_s, din_s, resync;
  logic              wr_en, cmd_idle;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [MAX_W-1:0]  rd_data, wr_data;
  logic [CNT_W-1:0]  bit_cnt;

  sp_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .fall(fall), .cs_s(cs_s), .din_s(din_s)
  );

  sp_ones_det #(.LIMIT(RESYNC_ONES)) u_ones (
    .clk(clk), .rst_n(rst_n), .fall(fall), .cs_s(cs_s), .din_s(din_s),
    .resync(resync)
  );

  sp_frame u_frame (
    .clk(clk), .rst_n(rst_n), .fall(fall), .cs_s(cs_s), .din_s(din_s),
    .resync(resync), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_oe(dout_oe), .idle(cmd_idle), .bit_cnt(bit_cnt)
  );

  sp_reg_bank #(
    .MODE_RST(MODE_RST), .CTRL_RST(CTRL_RST),
    .FILT_RST(FILT_RST), .GPIO_RST(GPIO_RST)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .resync(resync),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .sample_in(sample_in),
    .mode_q(mode_o), .ctrl_q(ctrl_o), .filt_q(filt_o), .gpio_q(gpio_o)
  );
endmodule

// File: rtl/sp_regif_chk.sv
module sp_regif_chk
  import sp_regif_pkg::*;
#(
  parameter logic [W_BYTE-1:0] MODE_RST = 8'h00,
  parameter logic [W_BYTE-1:0] CTRL_RST = 8'h07,
  parameter logic [W_HALF-1:0] FILT_RST = 16'h0045,
  parameter logic [W_HALF-1:0] GPIO_RST = 16'h0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cs_s,
  input logic              dout_oe,
  input logic              wr_en,
  input logic              resync,
  input logic              cmd_idle,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [W_BYTE-1:0] mode_o,
  input logic [W_BYTE-1:0] ctrl_o,
  input logic [W_HALF-1:0] filt_o,
  input logic [W_HALF-1:0] gpio_o
);
  // R9: three cycles of synchroniser and output register after chip select
  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 3) |-> !dout_oe)
    else $error("dout driven while deselected");

  // R9: nothing commits while the port is deselected
  assert_no_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !wr_en)
    else $error("write committed while deselected");

  // R6 and R3: registers move only on a write strobe or a resync
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !resync) |=> ($stable(mode_o) && $stable(ctrl_o) &&
                             $stable(filt_o) && $stable(gpio_o)))
    else $error("register changed without a write");

  // R7: a resync restores the bank and the command phase
  assert_resync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> (cmd_idle && mode_o == MODE_RST && ctrl_o == CTRL_RST &&
                filt_o == FILT_RST && gpio_o == GPIO_RST))
    else $error("resync did not restore defaults");

  // R3: bit counter always holds a legal access length
  assert_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt != '0) && (bit_cnt <= CNT_W'(MAX_W)))
    else $error("bit counter out of range");
endmodule

bind serport_regif sp_regif_chk #(
  .MODE_RST(MODE_RST), .CTRL_RST(CTRL_RST),
  .FILT_RST(FILT_RST), .GPIO_RST(GPIO_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_s(cs_s), .dout_oe(dout_oe),
  .wr_en(wr_en), .resync(resync), .cmd_idle(cmd_idle), .bit_cnt(bit_cnt),
  .mode_o(mode_o), .ctrl_o(ctrl_o), .filt_o(filt_o), .gpio_o(gpio_o)
);

// File: tb/sim_serport_regif.sv
`timescale 1ns/1ps
module sim_serport_regif;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n, sclk, cs_n, din;
  logic        dout, dout_oe;
  logic [7:0]  status_in;
  logic [23:0] sample_in;
  logic [7:0]  mode_o, ctrl_o;
  logic [15:0] filt_o, gpio_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [23:0] model [0:5];

  always #4 clk = ~clk;

  serport_regif u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .dout(dout), .dout_oe(dout_oe), .status_in(status_in), .sample_in(sample_in),
    .mode_o(mode_o), .ctrl_o(ctrl_o), .filt_o(filt_o), .gpio_o(gpio_o)
  );

  function automatic int wid(input logic [3:0] a);
    if (a == 4'd3) return 24;
    if (a == 4'd4 || a == 4'd5) return 16;
    return 8;
  endfunction

  function automatic bit writable(input logic [3:0] a);
    return (a == 4'd1 || a == 4'd2 || a == 4'd4 || a == 4'd5);
  endfunction

  function automatic logic [23:0] expect_rd(input logic [3:0] a);
    if (a == 4'd0) return {16'h0, status_in};
    if (a == 4'd3) return sample_in;
    if (writable(a)) return model[a];
    return 24'h0;
  endfunction

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_defaults();
    model[0] = 24'h0; model[1] = 24'h00; model[2] = 24'h07;
    model[3] = 24'h0; model[4] = 24'h0045; model[5] = 24'h0000;
  endtask

  task automatic check_outs(input string tag);
    check({tag, " mode"}, {16'h0, mode_o}, model[1]);
    check({tag, " ctrl"}, {16'h0, ctrl_o}, model[2]);
    check({tag, " filt"}, {8'h0, filt_o}, model[4]);
    check({tag, " gpio"}, {8'h0, gpio_o}, model[5]);
  endtask

  // one serial bit: sample dout while SCLK high, then the active falling edge
  task automatic bit_io(input logic b, input bit flip, output logic so, output logic oe);
    din = b;
    tick(H);
    so = dout;
    oe = dout_oe;
    sclk = 1'b0;
    tick(H);
    if (flip) din = ~b;
    sclk = 1'b1;
  endtask

  task automatic xfer(input int n, input logic [23:0] v, input bit flip,
                      output logic [23:0] got, output bit oe_all);
    got = '0;
    oe_all = 1;
    for (int i = n - 1; i >= 0; i--) begin
      logic so, oe;
      bit_io(v[i], flip, so, oe);
      got[i] = so;
      if (oe !== 1'b1) oe_all = 0;
    end
    din = 1'b0;
    tick(H);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [23:0] v);
    logic [23:0] g; bit o;
    xfer(8, {16'h0, 4'b0000, a}, 0, g, o);
    xfer(wid(a), v, 0, g, o);
    if (writable(a)) model[a] = v & ((24'h1 << wid(a)) - 1);
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [23:0] v, output bit oe_ok);
    logic [23:0] g; bit o;
    xfer(8, {16'h0, 4'b0100, a}, 0, g, o);
    xfer(wid(a), 24'h0, 0, v, oe_ok);
  endtask

  task automatic ones(input int n);
    logic [23:0] g; bit o;
    for (int k = 0; k < n; k++) xfer(1, 24'h1, 0, g, o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] v, g;
    bit ok, o;
    void'($urandom(32'd9127));
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b0;
    status_in = 8'h5A; sample_in = 24'hC3A501;
    set_defaults();
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R1: reset state
    check("R1 oe after reset", {23'h0, dout_oe}, 24'h0);
    check_outs("R1 reset value");
    cs_n = 1'b0;
    tick(H);
    // R1 R4: first transfer is a command; read status
    rd_reg(4'd0, v, ok);
    check("R1 R4 status read", v, 24'h5A);
    check("R4 oe during read", {23'h0, ok}, 24'h1);
    // R4: 24-bit sample read
    rd_reg(4'd3, v, ok);
    check("R4 sample read", v, 24'hC3A501);
    // R2: reserved bits 5..4 set in a write command
    xfer(8, 24'h31, 0, g, o);
    xfer(8, 24'h9E, 0, g, o);
    model[1] = 24'h9E;
    check("R2 reserved bits ignored", {16'h0, mode_o}, 24'h9E);
    // R2: command with bit 7 set is discarded
    xfer(8, 24'hC5, 0, g, o);
    rd_reg(4'd1, v, ok);
    check("R2 invalid command dropped", v, 24'h9E);
    // R8: DIN inverted while SCLK low must not be taken
    xfer(8, 24'h02, 1, g, o);
    xfer(8, 24'hB4, 1, g, o);
    model[2] = 24'hB4;
    check("R8 falling edge sampling", {16'h0, ctrl_o}, 24'hB4);
    // R6: writes to read-only and unmapped addresses
    wr_reg(4'd3, 24'hFFF0F0);
    wr_reg(4'd0, 24'h33);
    wr_reg(4'd9, 24'h66);
    check_outs("R6 read-only write");
    rd_reg(4'd9, v, ok);
    check("R6 unmapped read zero", v, 24'h0);
    // R11 R3 R4 R5 R6: random back-to-back traffic with chip select held low
    for (int it = 0; it < 40; it++) begin
      logic [3:0] a;
      a = 4'($urandom_range(0, 7));
      status_in = 8'($urandom);
      sample_in = 24'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr_reg(a, 24'($urandom));
        check_outs("R3 R11 random write");
      end else begin
        rd_reg(a, v, ok);
        check("R4 R5 R11 random read", v, expect_rd(a));
      end
    end
    // R9: abort a write by raising chip select partway through
    v = model[4];
    xfer(8, 24'h04, 0, g, o);
    xfer(8, 24'hA5, 0, g, o);
    cs_n = 1'b1;
    tick(H);
    check("R9 oe released", {23'h0, dout_oe}, 24'h0);
    cs_n = 1'b0;
    tick(H);
    check("R9 partial write discarded", {8'h0, filt_o}, v);
    rd_reg(4'd4, g, ok);
    check("R9 port back at command", g, v);
    // R10: chip select framing with read pending
    wr_reg(4'd5, 24'h8123);
    xfer(8, 24'h45, 0, g, o);
    cs_n = 1'b1;
    tick(2 * H);
    cs_n = 1'b0;
    tick(H);
    check("R10 MSB at select", {22'h0, dout_oe, dout}, 24'h3);
    xfer(16, 24'h0, 0, g, o);
    check("R10 framed read data", g, 24'h8123);
    // R7: 31 ones then a zero changes nothing
    wr_reg(4'd1, 24'h3C);
    ones(31);
    xfer(1, 24'h0, 0, g, o);
    check_outs("R7 31 ones");
    // R7: 32 ones restores defaults
    ones(32);
    set_defaults();
    check_outs("R7 32 ones");
    rd_reg(4'd1, v, ok);
    check("R7 port usable after resync", v, 24'h00);
    // R7: ones run starting inside a 16-bit write
    xfer(8, 24'h04, 0, g, o);
    ones(16);
    check("R7 write commits first", {8'h0, filt_o}, 24'hFFFF);
    ones(16);
    check_outs("R7 mid-write resync");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule